// File: doc/BRIEF.md
# Request-Gated Reference Clock Pair Stopper

This block turns a bank of free-running true/complement reference clock pairs on and off under two active-low, asynchronous request lines (line A and line B). Each output pair is modelled as a registered phase that toggles on every rising edge of the source clock `clk`, so one pair period spans two source-clock cycles. A pair is either driven, with its true leg following the phase and its complement leg opposite, or parked, with both legs low and its drive-enable low.

Two per-output map vectors choose which line may stop which pair. The usual register default routes line A to SRC4 (bit 3) and line B to SRC5 (bit 4). Each line passes through a two-flop synchronizer and a stability filter. Every pair then runs its own small state machine with three states. `PS_RUN` drives the pair. `PS_OFF` parks it. `PS_WAKE` counts down a fixed resume delay. The transitions are: RUN to OFF when a stop is wanted and the true leg is high, so the final high half-period is kept whole. OFF to WAKE when the stop is withdrawn. WAKE to RUN when the count expires. WAKE back to OFF if a stop returns. A strap input chooses whether the two shared pins serve as request inputs at all. When they do, the pair in the slot those pins would otherwise drive (SRC6) is held parked.

Top module: `srcreq_gate`

## Requirements
- R1: While `rst_n` is low, every pair is driven: `pair_oe` is all ones, `pair_t` is all zeros and `pair_c` is all ones.
- R2: A driven pair has its complement leg equal to the inverse of its true leg, and its true leg toggles on every `clk` rising edge.
- R3: A request pin passes through two synchronizer flops. A new level is accepted only when it is seen unchanged on two consecutive `clk` edges after synchronization. A high pulse that covers a single rising edge has no effect on any output, and a pulse that covers two edges is accepted.
- R4: A high level on a request pin (pin value 1 means stop), first sampled at edge n, removes the drive of each mapped pair after edge n+4 or edge n+5. The removal happens on the edge where the true leg would fall, so the last driven true value is 1.
- R5: A parked pair has `pair_oe`, `pair_t` and `pair_c` all at 0 for that bit.
- R6: A low level on the request pin, first sampled at edge m, makes every pair held only by that line driven again exactly after edge m+9. This is 3 edges of synchronizing and filtering plus a resume delay of 2×RESUME_PER cycles (RESUME_PER=3). All such pairs resume together.
- R7: Bit k of `map_a`/`map_b` lets line A/B stop pair k (pair k is SRC(k+1)). Pairs not mapped to a stopping line stay driven in every cycle.
- R8: A pair mapped to both lines is stopped when either line requests a stop. It stays parked until both lines have withdrawn their requests.
- R9: With `req_pin_mode` = 0, both request pins are ignored and all pairs, including slot 5, run. With `req_pin_mode` = 1, pair slot 5 is parked, regardless of the map bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin_mode | input | 1 | Strap: 1 = shared pins are request inputs, 0 = pins carry slot-5 output |
| req_a_n | input | 1 | Request line A, active low (high asks to stop), asynchronous |
| req_b_n | input | 1 | Request line B, active low (high asks to stop), asynchronous |
| map_a | input | 7 | Per-pair permission for line A to stop it |
| map_b | input | 7 | Per-pair permission for line B to stop it |
| pair_t | output | 7 | True leg of each pair |
| pair_c | output | 7 | Complement leg of each pair |
| pair_oe | output | 7 | Drive enable of each pair |

## Verification
The hardest thing to reach from the ports is the exact edge on which a pair stops or restarts. That edge depends on the pair phase at the moment the filtered request arrives, and the filter itself hides part of the latency. The bench drives each request pin half a cycle before a known edge. It then counts edges from that point: it accepts a stop only after edge n+4 or n+5 with a high true leg just before, and it demands a restart after exactly edge m+9. The filter is probed with pulses covering one edge and two edges. Dual mapping is checked by releasing one line while the other still holds its request.

// File: rtl/srcreq_pkg.sv
package srcreq_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_OFF  = 2'd1,
        PS_WAKE = 2'd2
    } pair_state_e;

endpackage

// File: rtl/srcreq_filt.sv
module srcreq_filt (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic stop_o
);

    logic sync1_q;
    logic sync2_q;
    logic hist_q;
    logic filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            hist_q  <= 1'b0;
            filt_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
            if (sync2_q == hist_q) begin
                filt_q <= sync2_q;
            end
        end
    end

    assign stop_o = filt_q;

    // R3
    filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> (hist_q == filt_q && $past(sync2_q) == filt_q));

endmodule

// File: rtl/srcreq_pair.sv
module srcreq_pair
    import srcreq_pkg::*;
#(
    parameter int WAKE_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic stop_i,
    output logic t_o,
    output logic c_o,
    output logic oe_o
);

    localparam int CW = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] WAKE_LOAD = CW'(WAKE_CYC - 2);

    pair_state_e state_q;
    pair_state_e state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:  if (stop_i && phase_i) state_d = PS_OFF;
            PS_OFF:  if (!stop_i) state_d = PS_WAKE;
            PS_WAKE: begin
                if (stop_i) begin
                    state_d = PS_OFF;
                end else if (cnt_q == '0) begin
                    state_d = PS_RUN;
                end
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == PS_OFF && state_d == PS_WAKE) begin
            cnt_q <= WAKE_LOAD;
        end else if (state_q == PS_WAKE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        oe_o = (state_q == PS_RUN);
        t_o  = oe_o & phase_i;
        c_o  = oe_o & ~phase_i;
    end

    // R4
    stop_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> $past(t_o));

    // R6
    resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> ($past(!stop_i) && $past(!stop_i, 2)));

endmodule

// File: rtl/srcreq_gate.sv
module srcreq_gate #(
    parameter int N_OUT      = 7,
    parameter int SLOT_IDX   = 5,
    parameter int RESUME_PER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_pin_mode,
    input  logic             req_a_n,
    input  logic             req_b_n,
    input  logic [N_OUT-1:0] map_a,
    input  logic [N_OUT-1:0] map_b,
    output logic [N_OUT-1:0] pair_t,
    output logic [N_OUT-1:0] pair_c,
    output logic [N_OUT-1:0] pair_oe
);

    localparam int WAKE_CYC = 2 * RESUME_PER;
    localparam int N_LINE   = 2;

    logic              phase_q;
    logic [N_LINE-1:0] line_pin;
    logic [N_LINE-1:0] line_stop;
    logic [N_OUT-1:0]  want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign line_pin = {req_b_n, req_a_n};

    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        srcreq_filt u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (line_pin[g]),
            .stop_o (line_stop[g])
        );
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_pair
        localparam bit IS_SLOT = (k == SLOT_IDX);

        assign want[k] = req_pin_mode &
                         (IS_SLOT | (map_a[k] & line_stop[0]) | (map_b[k] & line_stop[1]));

        srcreq_pair #(
            .WAKE_CYC (WAKE_CYC)
        ) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .phase_i (phase_q),
            .stop_i  (want[k]),
            .t_o     (pair_t[k]),
            .c_o     (pair_c[k]),
            .oe_o    (pair_oe[k])
        );

        // R7
        stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pair_oe[k]) |-> $past(want[k]));

        if (IS_SLOT) begin : g_slot
            // R9
            slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_pin_mode && $past(req_pin_mode) && $past(req_pin_mode, 2) && $past(rst_n, 2))
                |-> !pair_oe[k]);
        end
    end

endmodule

// File: tb/srcreq_gate_tb.sv
module srcreq_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_pin_mode;
    logic       req_a_n;
    logic       req_b_n;
    logic [6:0] map_a;
    logic [6:0] map_b;
    logic [6:0] pair_t;
    logic [6:0] pair_c;
    logic [6:0] pair_oe;

    always #5 clk = ~clk;

    srcreq_gate u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_pin_mode (req_pin_mode),
        .req_a_n      (req_a_n),
        .req_b_n      (req_b_n),
        .map_a        (map_a),
        .map_b        (map_b),
        .pair_t       (pair_t),
        .pair_c       (pair_c),
        .pair_oe      (pair_oe)
    );

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    int  drop_at;
    int  rise_at;
    bit  prev_t;
    bit  high_before;
    bit  others_ok;
    bit  saw_drop;
    logic [6:0] t_prev;

    // {mode, map_a, map_b, pin_a, pin_b, expected pair_oe}
    localparam logic [23:0] VEC [12] = '{
        {1'b1, 7'h08, 7'h10, 1'b0, 1'b0, 7'h5F},
        {1'b1, 7'h08, 7'h10, 1'b1, 1'b0, 7'h57},
        {1'b1, 7'h08, 7'h10, 1'b0, 1'b1, 7'h4F},
        {1'b1, 7'h08, 7'h10, 1'b1, 1'b1, 7'h47},
        {1'b1, 7'h41, 7'h01, 1'b0, 1'b1, 7'h5E},
        {1'b1, 7'h41, 7'h01, 1'b1, 1'b0, 7'h1E},
        {1'b1, 7'h41, 7'h01, 1'b0, 1'b0, 7'h5F},
        {1'b1, 7'h01, 7'h01, 1'b1, 1'b1, 7'h5E},
        {1'b1, 7'h01, 7'h01, 1'b0, 1'b1, 7'h5E},
        {1'b0, 7'h7F, 7'h7F, 1'b1, 1'b1, 7'h7F},
        {1'b1, 7'h7F, 7'h7F, 1'b1, 1'b0, 7'h00},
        {1'b1, 7'h00, 7'h00, 1'b1, 1'b1, 7'h5F}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        req_pin_mode = 1'b1;
        req_a_n      = 1'b0;
        req_b_n      = 1'b0;
        map_a        = 7'h08;
        map_b        = 7'h10;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pair_oe == 7'h7F, "R1 oe", 32'(pair_oe), 32'h7F);
        chk(pair_t == 7'h00, "R1 true", 32'(pair_t), 32'h00);
        chk(pair_c == 7'h7F, "R1 comp", 32'(pair_c), 32'h7F);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            req_pin_mode = VEC[i][23];
            map_a        = VEC[i][22:16];
            map_b        = VEC[i][15:9];
            req_a_n      = VEC[i][8];
            req_b_n      = VEC[i][7];
            repeat (16) @(negedge clk);
            t_prev = pair_t;
            if (i == 8) begin
                // R8 one line released, the other still holds the shared pair
                chk(pair_oe == VEC[i][6:0], "R8 dual map", 32'(pair_oe), 32'(VEC[i][6:0]));
            end else if (i == 9) begin
                // R9 pins ignored, slot runs
                chk(pair_oe == VEC[i][6:0], "R9 strap off", 32'(pair_oe), 32'(VEC[i][6:0]));
            end else begin
                // R7 mapping and R9 slot parked
                chk(pair_oe == VEC[i][6:0], "R7 map", 32'(pair_oe), 32'(VEC[i][6:0]));
            end
            // R5 parked legs low
            chk(((pair_t | pair_c) & ~pair_oe) == 7'h00, "R5 parked",
                32'((pair_t | pair_c) & ~pair_oe), 32'h0);
            // R2 complement is inverse of true on driven pairs
            chk(pair_c == (~pair_t & VEC[i][6:0]), "R2 comp", 32'(pair_c), 32'(~pair_t & VEC[i][6:0]));
            @(negedge clk);
            chk((pair_t ^ t_prev) == VEC[i][6:0], "R2 toggle", 32'(pair_t ^ t_prev), 32'(VEC[i][6:0]));
        end

        // Directed stop timing on line A
        req_pin_mode = 1'b1;
        map_a   = 7'h08;
        map_b   = 7'h10;
        req_a_n = 1'b0;
        req_b_n = 1'b0;
        repeat (16) @(negedge clk);
        req_a_n     = 1'b1;
        drop_at     = -1;
        prev_t      = pair_t[3];
        high_before = 1'b0;
        others_ok   = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!pair_oe[3] && drop_at < 0) begin
                drop_at     = i;
                high_before = prev_t;
            end
            prev_t = pair_t[3];
            if ((pair_oe & 7'h57) != 7'h57) others_ok = 1'b0;
        end
        chk(drop_at == 4 || drop_at == 5, "R4 stop edge", 32'(drop_at), 32'd4);
        chk(high_before, "R4 last high", 32'(high_before), 32'd1);
        chk(others_ok, "R7 unmapped undisturbed", 32'(others_ok), 32'd1);
        chk(pair_t[3] == 1'b0 && pair_c[3] == 1'b0, "R5 legs low", 32'({pair_t[3], pair_c[3]}), 32'd0);

        // Directed resume timing
        req_a_n = 1'b0;
        rise_at = -1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pair_oe[3] && rise_at < 0) rise_at = i;
        end
        chk(rise_at == 9, "R6 resume edge", 32'(rise_at), 32'd9);

        // R3 single-edge pulse on line B ignored
        repeat (8) @(negedge clk);
        req_b_n = 1'b1;
        @(negedge clk);
        req_b_n   = 1'b0;
        others_ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!pair_oe[4]) others_ok = 1'b0;
        end
        chk(others_ok, "R3 one-edge pulse", 32'(others_ok), 32'd1);

        // R3 two-edge pulse on line B accepted
        req_b_n = 1'b1;
        repeat (2) @(negedge clk);
        req_b_n  = 1'b0;
        saw_drop = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!pair_oe[4]) saw_drop = 1'b1;
        end
        chk(saw_drop, "R3 two-edge pulse", 32'(saw_drop), 32'd1);

        repeat (12) @(negedge clk);
        chk(pair_oe == 7'h5F, "R6 restored", 32'(pair_oe), 32'h5F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule